// File: doc/BRIEF.md
# Translation Buffer Entry Store

This block holds the entries of a software-managed address translation buffer. It supports the two indexed commands that system software uses to maintain it. An indexed write takes the current staging values and places them in the slot named by an index. On the way in it keeps only the meaningful bits of each word, folds the two per-page global bits into one flag, and precomputes the bit position where the page offset ends. An indexed read returns the stored contents of a slot one cycle later, so software can restore them into its staging registers.

Lookup, probing and refill handling live elsewhere. They consume the stored page mask, the boundary position and the global flag directly from this store.

Top module: `tlb_entry_store`

## Requirements
- R1: After reset every slot reads back as all zeros, including the page mask, both low words, the high word and the boundary position.
- R2: The high word is stored ANDed with 0xC000_00FF_FFFF_E0FF. Only bits 63:62, 39:13 and 7:0 survive.
- R3: Each low word is stored ANDed with 0x3FFF_FFFE. Bits 31:30 read back as zero, and bits 29:1 are returned as written.
- R4: The global flag is 1 only when bit 0 is 1 in both low words written together. On readback, bit 0 of both returned low words equals that flag.
- R5: The page mask is stored and returned unchanged, all 32 bits.
- R6: The stored boundary position equals 32 minus the count of leading zeros of the 32-bit value ((mask >> 1) OR 0xFFF). A zero mask gives 12, 0x6000 gives 14, and 0x01FF_E000 gives 24.
- R7: A write whose index is ENTRIES (default 48) or above changes no slot.
- R8: A read issued in cycle n sets `rd_valid` and the read data in cycle n+1 only. A read whose index is out of range returns all zeros.
- R9: When a read and a write name the same index in the same cycle, the read returns the contents from before the write.
- R10: A write changes only the slot it names.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Indexed write command |
| wr_idx | input | IDX_W | Slot targeted by the write |
| wr_mask | input | 32 | Page mask staging value |
| wr_hi | input | 64 | High word staging value |
| wr_lo0 | input | 32 | Low word for the even page |
| wr_lo1 | input | 32 | Low word for the odd page |
| rd_en | input | 1 | Indexed read command |
| rd_idx | input | IDX_W | Slot targeted by the read |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_mask | output | 32 | Returned page mask |
| rd_hi | output | 64 | Returned masked high word |
| rd_lo0 | output | 32 | Returned even low word, bit 0 is the global flag |
| rd_lo1 | output | 32 | Returned odd low word, bit 0 is the global flag |
| rd_lowbit | output | 6 | Returned page-offset boundary position |

## Verification
The bench writes all-ones words. A design that applies the wrong keep pattern lets through a high-word bit between 8 and 12 or above 39, or a low-word bit 30 or 31. It writes slots where only one of the two global bits is set; a design that uses OR, or passes bit 0 through, returns a mismatched or wrong flag. It writes with index 48 and 63, which an unguarded decoder would alias onto a real slot. It also reads and writes the same slot in one cycle, where a write-through read path would return the new data. Masks of several page sizes exercise the boundary position, and an off-by-one count in it shows up as 11 or 13 instead of 12.

// File: rtl/tlb_store_pkg.sv
package tlb_store_pkg;
  localparam int MASK_W = 32;
  localparam int HI_W   = 64;
  localparam int LO_W   = 32;
  localparam int POS_W  = 6;

  localparam logic [HI_W-1:0] HI_KEEP = 64'hC000_00FF_FFFF_E0FF;
  localparam logic [LO_W-1:0] LO_KEEP = 32'h3FFF_FFFE;
  localparam logic [MASK_W-1:0] MIN_PAGE = 32'h0000_0FFF;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [HI_W-1:0]   hi;
    logic [LO_W-1:0]   lo0;
    logic [LO_W-1:0]   lo1;
    logic              glob;
    logic [POS_W-1:0]  lowbit;
  } slot_t;

  // Position one above the highest set bit of the widened mask.
  function automatic logic [POS_W-1:0] boundary_pos(input logic [MASK_W-1:0] pm);
    logic [MASK_W-1:0] v;
    logic [POS_W-1:0]  r;
    v = (pm >> 1) | MIN_PAGE;
    r = '0;
    for (int b = 0; b < MASK_W; b++)
      if (v[b]) r = POS_W'(b + 1);
    return r;
  endfunction
endpackage

// File: rtl/tlb_slot_fmt.sv
module tlb_slot_fmt
  import tlb_store_pkg::*;
(
  input  logic [MASK_W-1:0] mask_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [LO_W-1:0]   lo0_i,
  input  logic [LO_W-1:0]   lo1_i,
  output slot_t             slot_o
);
  always_comb begin
    slot_o.mask   = mask_i;
    slot_o.hi     = hi_i & HI_KEEP;
    slot_o.lo0    = lo0_i & LO_KEEP;
    slot_o.lo1    = lo1_i & LO_KEEP;
    slot_o.glob   = lo0_i[0] & lo1_i[0];
    slot_o.lowbit = boundary_pos(mask_i);
  end
endmodule

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
  import tlb_store_pkg::*;
#(
  parameter int ENTRIES = 48,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  slot_t            wr_slot,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output slot_t            rd_slot
);
  slot_t slots [ENTRIES];
  slot_t sel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) slots[e] <= '0;
      else if (wr_en && wr_idx == IDX_W'(e)) slots[e] <= wr_slot;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rd_idx == IDX_W'(i)) sel = slots[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_slot  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_slot <= sel;
    end
  end

  // R8: read strobe answered exactly one cycle later
  p_rd_follow_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R9: read data comes from the slot contents before a same-cycle write
  p_rd_old_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && rd_idx == wr_idx && rd_idx < IDX_W'(ENTRIES))
      |=> rd_slot == $past(sel));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_store_pkg::*;
#(
  parameter int ENTRIES = 48,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_mask,
  input  logic [63:0]       wr_hi,
  input  logic [31:0]       wr_lo0,
  input  logic [31:0]       wr_lo1,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [31:0]       rd_mask,
  output logic [63:0]       rd_hi,
  output logic [31:0]       rd_lo0,
  output logic [31:0]       rd_lo1,
  output logic [5:0]        rd_lowbit
);
  slot_t new_slot;
  slot_t out_slot;
  logic  wr_ok;

  assign wr_ok = wr_en && (wr_idx < IDX_W'(ENTRIES));

  tlb_slot_fmt u_fmt (
    .mask_i (wr_mask),
    .hi_i   (wr_hi),
    .lo0_i  (wr_lo0),
    .lo1_i  (wr_lo1),
    .slot_o (new_slot)
  );

  tlb_slot_array #(.ENTRIES(ENTRIES)) u_array (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_ok),
    .wr_idx   (wr_idx),
    .wr_slot  (new_slot),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_slot  (out_slot)
  );

  assign rd_mask   = out_slot.mask;
  assign rd_hi     = out_slot.hi;
  assign rd_lo0    = {out_slot.lo0[LO_W-1:1], out_slot.glob};
  assign rd_lo1    = {out_slot.lo1[LO_W-1:1], out_slot.glob};
  assign rd_lowbit = out_slot.lowbit;

  // R4: both returned low words carry the same global flag
  p_glob_same_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> rd_lo0[0] == rd_lo1[0]);
  // R2: no bit outside the kept high-word fields is ever returned
  p_hi_clean_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_hi & ~HI_KEEP) == '0);
  // R3: top low-word bits read back as zero
  p_lo_clean_r3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_lo0[31:30] == 2'b00 && rd_lo1[31:30] == 2'b00));
  // R6: boundary is zero (reset slot) or between 12 and 32
  p_pos_range_r6: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_lowbit == 6'd0 || (rd_lowbit >= 6'd12 && rd_lowbit <= 6'd32)));
endmodule

// File: tb/tlb_entry_store_test.sv
module tlb_entry_store_test;
  localparam int CLK_NS  = 10;
  localparam int ENTRIES = 48;
  localparam int IDX_W   = $clog2(ENTRIES);

  typedef struct {
    logic [31:0] mask;
    logic [63:0] hi;
    logic [31:0] lo0;
    logic [31:0] lo1;
    logic [5:0]  pos;
    string       tag;
  } exp_t;

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0;
  logic [IDX_W-1:0] wr_idx = '0, rd_idx = '0;
  logic [31:0] wr_mask = '0, wr_lo0 = '0, wr_lo1 = '0;
  logic [63:0] wr_hi = '0;
  logic rd_valid;
  logic [31:0] rd_mask, rd_lo0, rd_lo1;
  logic [63:0] rd_hi;
  logic [5:0]  rd_lowbit;

  int checks = 0, errors = 0;
  exp_t sb[$];
  exp_t model [ENTRIES];

  always #(CLK_NS/2) clk = ~clk;

  tlb_entry_store #(.ENTRIES(ENTRIES)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_hi(wr_hi), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_mask(rd_mask), .rd_hi(rd_hi), .rd_lo0(rd_lo0),
    .rd_lo1(rd_lo1), .rd_lowbit(rd_lowbit));

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t ref_slot(input logic [31:0] m, input logic [63:0] h,
                                    input logic [31:0] l0, input logic [31:0] l1);
    exp_t e;
    logic g;
    logic [32:0] v;
    g = l0[0] & l1[0];
    v = {1'b0, (m >> 1) | 32'hFFF};
    e.mask = m;
    e.hi   = h & 64'hC000_00FF_FFFF_E0FF;
    e.lo0  = (l0 & 32'h3FFF_FFFE) | {31'd0, g};
    e.lo1  = (l1 & 32'h3FFF_FFFE) | {31'd0, g};
    e.pos  = 6'($clog2(v + 33'd1));
    e.tag  = "";
    return e;
  endfunction

  // Drive one cycle of commands; expected read result comes from the model before the write
  task automatic cycle(input logic we, input int wi, input logic [31:0] m, input logic [63:0] h,
                       input logic [31:0] l0, input logic [31:0] l1,
                       input logic re, input int ri, input string tag);
    exp_t e;
    wr_en = we; wr_idx = IDX_W'(wi); wr_mask = m; wr_hi = h; wr_lo0 = l0; wr_lo1 = l1;
    rd_en = re; rd_idx = IDX_W'(ri);
    if (re) begin
      if (ri < ENTRIES) e = model[ri];
      else begin e = '{default:'0}; e.tag = ""; end
      e.tag = tag;
      sb.push_back(e);
    end
    if (we && wi < ENTRIES) model[wi] = ref_slot(m, h, l0, l1);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input int i, input logic [31:0] m, input logic [63:0] h,
                    input logic [31:0] l0, input logic [31:0] l1);
    cycle(1, i, m, h, l0, l1, 0, 0, "");
  endtask

  task automatic rd(input int i, input string tag);
    cycle(0, 0, '0, '0, '0, '0, 1, i, tag);
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        if (sb.size() == 0) begin
          cmp("R8", "unexpected rd_valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          cmp(e.tag, "mask", 64'(rd_mask), 64'(e.mask));
          cmp(e.tag, "hi", rd_hi, e.hi);
          cmp(e.tag, "lo0", 64'(rd_lo0), 64'(e.lo0));
          cmp(e.tag, "lo1", 64'(rd_lo1), 64'(e.lo1));
          cmp(e.tag, "lowbit", 64'(rd_lowbit), 64'(e.pos));
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin model[i] = '{default:'0}; model[i].tag = ""; end
    @(negedge clk); @(negedge clk);
    rst = 0;
    cmp("R8", "rd_valid after reset", 64'(rd_valid), 0);
    // R1: reset contents
    rd(0, "R1"); rd(47, "R1");
    // R2 R3 R5 R6: all-ones staging, 4 KB page
    wr(3, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(3, "R2_R3_R4");
    // R4: only one global bit set, each way
    wr(5, 32'h0000_6000, 64'h1234_5678_9ABC_DEF0, 32'h0000_0001, 32'h2AAA_AAAA);
    rd(5, "R4_R6");
    wr(6, 32'h01FF_E000, 64'h8000_0012_3456_7F3C, 32'h1555_5554, 32'h0000_0003);
    rd(6, "R4_R6");
    // R5 R6: odd-looking mask stored verbatim
    wr(7, 32'hDEAD_BEEF, 64'h0, 32'h0, 32'h0);
    rd(7, "R5_R6");
    // R10: neighbours untouched
    rd(4, "R10"); rd(2, "R10");
    // R7: out-of-range writes ignored, every slot checked afterwards
    wr(48, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(63, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int i = 0; i < ENTRIES; i++) rd(i, "R7");
    // R8: out-of-range read returns zero
    rd(50, "R8");
    // R9: same-cycle write and read of one slot returns old contents
    cycle(1, 5, 32'h0, 64'hFFFF_0000_FFFF_0000, 32'h3, 32'h3, 1, 5, "R9");
    rd(5, "R9_new");
    // back-to-back reads, R8
    rd(3, "R8"); rd(6, "R8"); rd(47, "R8");
    @(negedge clk); @(negedge clk);
    cmp("R8", "rd_valid idle", 64'(rd_valid), 0);
    cmp("R8", "scoreboard drained", 64'(sb.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule